// File: doc/BRIEF.md
# Divided Word-Line Row and Column Selector

This block models, cycle by cycle, the selection path of a memory array that is cut into column blocks. A registered address is split into three fields. The row field drives a global word-line through a two-stage decoder. The first stage turns each 2-bit slice of the row field into four one-hot lines, and the second stage ANDs one line from each slice. The block field drives one vertical block-select line. Each local word-line is the AND of one global word-line and one block select. As a result, an access drives only the cells of one segment of one row. A one-hot column select picks the wanted column inside the chosen block.

Selection is pulsed, not held. A transition detector compares the registered address with the value it had one cycle earlier. When the two differ, it loads an enable window of `PULSE_LEN` cycles. Every select output is forced to zero when that window is closed or when `chip_en` is low. The surrounding logic changes `addr` to start an access and reads the selects during the window.

Top module: `dwl_row_select`

## Requirements
- R1: The address bits are split as follows: bits [CW-1:0] give the column inside the block, the next BW bits give the block index, and the top RW bits give the row. During an enabled window, `gwl` is one-hot at the row index, `bsel` is one-hot at the block index and `csel` is one-hot at the column index.
- R2: Local word-line bit `row*NB + blk` is high only when global line `row` and block select `blk` are both high. Every other local bit stays low.
- R3: During an enabled window, exactly one bit of `lwl` is set. At all times, at most one bit of `lwl` is set.
- R4: An address that differs from the previous registered address opens a window. Take the clock edge that registers the new address as edge 0. Then `en_pulse` is high after edges 1 through PULSE_LEN and low after edge PULSE_LEN+1, unless a further change occurs.
- R5: Presenting the same address again does not open a window. All selects stay zero.
- R6: An address change while a window is open decodes the new address at once. It also reloads the window, so the window ends PULSE_LEN cycles after the reload.
- R7: While `chip_en` is low, `gwl`, `bsel`, `lwl` and `csel` are all zero. The window timing in `en_pulse` still runs.
- R8: After reset, every output is zero and the registered address is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Global enable for all select lines |
| addr | input | AW | Access address (column, block, row fields from LSB) |
| gwl | output | ROWS | Global word-lines |
| bsel | output | NB | Block-select lines |
| lwl | output | ROWS*NB | Local word-lines, bit row*NB+blk |
| csel | output | NC/NB | Column select within the selected block |
| en_pulse | output | 1 | Enable window from the transition detector |

## Verification
The assertions assume that `chip_en` and `addr` change only away from the rising edge. They also assume that reset is asserted before any access. The one-hot properties depend on the parameters being powers of two. The bench drives every input on the falling edge and keeps the parameters at powers of two. It sweeps every address, which opens a fresh window each time, and it starts the repeat and restart cases from a known idle state.

// File: rtl/dwl_row_select.sv
module dwl_row_select #(
  parameter int ROWS      = 16,
  parameter int NB        = 4,
  parameter int NC        = 32,
  parameter int PULSE_LEN = 3,
  localparam int CPB  = NC / NB,
  localparam int CW   = $clog2(CPB),
  localparam int BW   = $clog2(NB),
  localparam int RW   = $clog2(ROWS),
  localparam int AW   = CW + BW + RW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 chip_en,
  input  logic [AW-1:0]        addr,
  output logic [ROWS-1:0]      gwl,
  output logic [NB-1:0]        bsel,
  output logic [ROWS*NB-1:0]   lwl,
  output logic [CPB-1:0]       csel,
  output logic                 en_pulse
);
  localparam int NGRP = (RW + 1) / 2;
  localparam int CNTW = $clog2(PULSE_LEN + 1);

  logic [AW-1:0]     addr_q, addr_p;
  logic [CNTW-1:0]   cnt;
  logic              act;
  logic [RW-1:0]     row;
  logic [BW-1:0]     blk;
  logic [CW-1:0]     col;
  logic [2*NGRP-1:0] row_pad;
  logic [3:0]        pd [NGRP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      addr_p <= '0;
      cnt    <= '0;
    end else begin
      addr_q <= addr;
      addr_p <= addr_q;
      if (addr_q != addr_p)
        cnt <= CNTW'(PULSE_LEN);
      else if (cnt != '0)
        cnt <= cnt - 1'b1;
    end
  end

  assign en_pulse = (cnt != '0);
  assign act      = en_pulse & chip_en;
  assign col      = addr_q[CW-1:0];
  assign blk      = addr_q[CW +: BW];
  assign row      = addr_q[CW+BW +: RW];
  assign row_pad  = (2*NGRP)'(row);

  generate
    for (genvar g = 0; g < NGRP; g++) begin : g_pre
      assign pd[g] = act ? (4'b0001 << row_pad[2*g +: 2]) : 4'b0000;
    end
  endgenerate

  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      gwl[r] = 1'b1;
      for (int k = 0; k < NGRP; k++)
        gwl[r] = gwl[r] & pd[k][2'((r >> (2*k)) & 3)];
    end
  end

  assign bsel = act ? (NB'(1) << blk) : '0;
  assign csel = act ? (CPB'(1) << col) : '0;

  generate
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar b = 0; b < NB; b++) begin : g_blk
        assign lwl[r*NB + b] = gwl[r] & bsel[b];
      end
    end
  endgenerate
endmodule

// File: rtl/dwl_row_select_chk.sv
module dwl_row_select_chk #(
  parameter int ROWS = 16,
  parameter int NB   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chip_en,
  input logic [ROWS-1:0]   gwl,
  input logic [NB-1:0]     bsel,
  input logic [ROWS*NB-1:0] lwl,
  input logic              en_pulse
);
  // R1
  gwl_bsel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gwl) && $onehot0(bsel));

  // R2
  lwl_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|lwl) |-> ((|gwl) && (|bsel)));

  // R3
  lwl_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_pulse && chip_en) |-> ($countones(lwl) == 1));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_pulse |-> (lwl == '0 && gwl == '0 && bsel == '0));

  // R7
  chip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |-> (lwl == '0 && gwl == '0 && bsel == '0));
endmodule

bind dwl_row_select dwl_row_select_chk #(.ROWS(ROWS), .NB(NB)) chk_i (
  .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .gwl(gwl),
  .bsel(bsel), .lwl(lwl), .en_pulse(en_pulse)
);

// File: tb/dwl_row_select_tb_top.sv
`timescale 1ns/1ps
module dwl_row_select_tb_top;
  localparam int ROWS = 16, NB = 4, NC = 32, PL = 3;
  localparam int CPB = NC / NB;
  localparam int CW = $clog2(CPB), BW = $clog2(NB), RW = $clog2(ROWS);
  localparam int AW = CW + BW + RW;

  logic clk = 0, rst_n = 0, chip_en = 1;
  logic [AW-1:0] addr = '0;
  logic [ROWS-1:0] gwl;
  logic [NB-1:0] bsel;
  logic [ROWS*NB-1:0] lwl;
  logic [CPB-1:0] csel;
  logic en_pulse;
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dwl_row_select #(.ROWS(ROWS), .NB(NB), .NC(NC), .PULSE_LEN(PL)) dut_i (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .addr(addr), .gwl(gwl),
    .bsel(bsel), .lwl(lwl), .csel(csel), .en_pulse(en_pulse));

  task automatic check(string req, logic ep, logic on, int a);
    logic [ROWS-1:0] eg = '0;
    logic [NB-1:0] eb = '0;
    logic [ROWS*NB-1:0] el = '0;
    logic [CPB-1:0] ec = '0;
    int r = a >> (CW + BW), b = (a >> CW) % NB, c = a % CPB;
    if (on) begin eg[r] = 1; eb[b] = 1; el[r*NB + b] = 1; ec[c] = 1; end
    tests++;
    if (en_pulse !== ep || gwl !== eg || bsel !== eb || lwl !== el || csel !== ec) begin
      fails++;
      $display("FAIL %s addr=%0d: pulse=%b gwl=%h bsel=%h lwl=%h csel=%h exp pulse=%b gwl=%h bsel=%h lwl=%h csel=%h",
        req, a, en_pulse, gwl, bsel, lwl, csel, ep, eg, eb, el, ec);
    end
  endtask

  task automatic t_reset();
    @(negedge clk); check("R8", 0, 0, 0);
    rst_n = 1;
    @(negedge clk); check("R8", 0, 0, 0);
  endtask

  task automatic access(string req, int a);
    addr = AW'(a);
    @(negedge clk); check(req, 0, 0, a);
    for (int i = 0; i < PL; i++) begin @(negedge clk); check(req, 1, 1, a); end
    @(negedge clk); check("R4", 0, 0, a);
  endtask

  task automatic t_sweep();
    for (int a = 1; a <= (1 << AW); a++) begin
      @(negedge clk);
      access("R1/R2/R3", a % (1 << AW));
    end
  endtask

  task automatic t_same();
    @(negedge clk); access("R4", 37);
    addr = AW'(37);
    for (int i = 0; i < PL + 2; i++) begin @(negedge clk); check("R5", 0, 0, 37); end
  endtask

  task automatic t_restart();
    int a = 90, b = 301;
    @(negedge clk); addr = AW'(a);
    @(negedge clk); check("R6", 0, 0, a);
    @(negedge clk); check("R6", 1, 1, a);
    @(negedge clk); check("R6", 1, 1, a);
    addr = AW'(b);
    for (int i = 0; i < PL + 1; i++) begin @(negedge clk); check("R6", 1, 1, b); end
    @(negedge clk); check("R6", 0, 0, b);
  endtask

  task automatic t_chip_off();
    @(negedge clk); chip_en = 0; addr = AW'(455);
    @(negedge clk); check("R7", 0, 0, 455);
    for (int i = 0; i < PL; i++) begin @(negedge clk); check("R7", 1, 0, 455); end
    @(negedge clk); check("R7", 0, 0, 455);
    chip_en = 1;
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_same();
    t_restart();
    t_chip_off();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule